// File: doc/BRIEF.md
# UART Interrupt and DMA Request Controller

This block sits beside a UART/LIN serial core and turns the core's one-cycle event pulses into sticky raw interrupt flags. A per-source mask selects which flags reach the masked status and the single combined interrupt line. It also compares the receive and transmit FIFO fill levels against programmable thresholds, and from those comparisons it drives single and burst DMA requests for each direction.

A DMA-on-error option stops the receive DMA requests while any receive error flag (framing, parity, break or overrun) is raised. This lets software handle the faulty data before the DMA engine drains more bytes. Software reaches the block through a small register port. A write strobe, write address and write data program the mask, clear, level-select and DMA-control registers. A read address selects a value that appears combinationally on the read data output.

Top module: `uart_irq_dma_ctrl`

## Requirements
- R1: The event vector uses these source bit positions: 1 CTS change, 4 RX, 5 TX, 6 receive timeout, 7 framing error, 8 parity error, 9 break error, 10 overrun error, 11 end of transmission, 12 TX DMA done, 13 RX DMA done, 14 LIN break, 15 LIN break timeout, 16 LIN sync timeout. Pulses on bits 0, 2 and 3 are ignored, and those raw bits always read 0.
- R2: A raw flag sets in the clock edge that samples its event pulse. It stays set until it is cleared. Raw flags read at address 1.
- R3: Writing address 3 clears every raw flag whose data bit is 1 and leaves the other flags unchanged. If a flag sees a set and a clear in the same cycle, the set wins. Address 3 always reads 0.
- R4: Address 2 reads the masked status, which is the raw flags ANDed with the mask.
- R5: The mask register is at address 0, and each bit enables its source (1) or blocks it (0). After reset the mask is 0 and the interrupt line is low.
- R6: `irq_o` is high exactly when any masked status bit is 1.
- R7: The level register is at address 4. Bits 2:0 hold the receive code, bits 6:4 hold the transmit code, and the other bits read 0. Code 1 selects DEPTH/4, code 3 selects 3*DEPTH/4, and every other code selects DEPTH/2. Both codes reset to 2. `rx_lvl_o` is high when the receive fill is at or above its threshold.
- R8: `tx_lvl_o` is high when the transmit fill is at or below its threshold.
- R9: The DMA register is at address 5: bit 0 enables receive DMA, bit 1 enables transmit DMA and bit 2 enables DMA-on-error. It resets to 0. The receive single request is high when the receive fill is nonzero, and the receive burst request follows `rx_lvl_o`. The transmit single request is high when the transmit fill is below DEPTH, and the transmit burst request follows `tx_lvl_o`. Each request is high only when its direction is enabled.
- R10: While DMA-on-error is set and any raw flag at bits 7 to 10 is 1, both receive DMA requests are low. Transmit requests and non-error flags are unaffected.
- R11: Read addresses other than 0 to 5 return 0. A synchronous active-low reset returns all registers to their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 17 | One-cycle event pulses by source bit position |
| rx_fill_i | input | FILL_W | Receive FIFO fill count |
| tx_fill_i | input | FILL_W | Transmit FIFO fill count |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 17 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 17 | Register read data |
| irq_o | output | 1 | Combined interrupt |
| rx_lvl_o | output | 1 | Receive fill at or above threshold |
| tx_lvl_o | output | 1 | Transmit fill at or below threshold |
| rx_dma_single_o | output | 1 | Receive single DMA request |
| rx_dma_burst_o | output | 1 | Receive burst DMA request |
| tx_dma_single_o | output | 1 | Transmit single DMA request |
| tx_dma_burst_o | output | 1 | Transmit burst DMA request |

## Verification
The hardest situation to reach is a cycle in which an event pulse and a clear write hit the same flag. A second hard case is a receive error flag that blocks DMA while the receive fill is above threshold, followed by the release of that block when only that error is cleared. The stimulus makes both happen on purpose. It raises the clear strobe in the same cycle as a matching pulse, then fills the receive side past every threshold code and toggles each error source in turn with DMA-on-error set. Threshold edges are covered by sweeping the fill from 0 to DEPTH under all eight level codes.

// File: rtl/uirq_pkg.sv
// Shared constants and types for the UART interrupt and DMA request controller.
// Assumes a 17-bit source vector with fixed source positions.
package uirq_pkg;
    localparam int SRC_W = 17;
    localparam int REG_W = SRC_W;
    localparam int ADDR_W = 3;
    // Positions that carry a real source; 0, 2 and 3 are unused.
    localparam logic [SRC_W-1:0] SRC_VALID = 17'h1FFF2;
    // Framing, parity, break and overrun flags (bits 7..10).
    localparam logic [SRC_W-1:0] ERR_BITS = 17'h00780;

    typedef enum logic [ADDR_W-1:0] {
        A_MASK = 3'd0,
        A_RAW  = 3'd1,
        A_MSK  = 3'd2,
        A_CLR  = 3'd3,
        A_LVL  = 3'd4,
        A_DMA  = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic on_err;
        logic tx_en;
        logic rx_en;
    } dma_ctl_t;
endpackage

// File: rtl/uirq_flags.sv
// Sticky raw flags and their mask.
// Assumes one-cycle event pulses. A set beats a clear in the same cycle.
module uirq_flags
    import uirq_pkg::*;
#(
    parameter int W = SRC_W,
    parameter logic [W-1:0] VALID = SRC_VALID
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    input  logic [W-1:0] clr_i,
    input  logic         mask_we_i,
    input  logic [W-1:0] mask_d_i,
    output logic [W-1:0] raw_o,
    output logic [W-1:0] mask_o,
    output logic [W-1:0] masked_o
);
    logic [W-1:0] raw_q;
    logic [W-1:0] mask_q;

    // Raw flag update: clear first, then OR in new events.
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= (raw_q & ~clr_i) | (evt_i & VALID);
    end

    // Mask register load.
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_q <= '0;
        else if (mask_we_i) mask_q <= mask_d_i;
    end

    assign raw_o    = raw_q;
    assign mask_o   = mask_q;
    assign masked_o = raw_q & mask_q;
endmodule

// File: rtl/uirq_level.sv
// FIFO fill threshold compare.
// RISING=1 flags fill >= threshold; RISING=0 flags fill <= threshold.
// Assumes DEPTH is a multiple of 4.
module uirq_level #(
    parameter int DEPTH  = 16,
    parameter int FILL_W = $clog2(DEPTH + 1),
    parameter bit RISING = 1'b1
) (
    input  logic [2:0]        sel_i,
    input  logic [FILL_W-1:0] fill_i,
    output logic              hit_o
);
    localparam logic [FILL_W-1:0] T_QTR  = FILL_W'(DEPTH / 4);
    localparam logic [FILL_W-1:0] T_HALF = FILL_W'(DEPTH / 2);
    localparam logic [FILL_W-1:0] T_3QTR = FILL_W'((DEPTH * 3) / 4);

    logic [FILL_W-1:0] thr;

    // Decode the level code into a fill threshold.
    always_comb begin
        unique case (sel_i)
            3'd1:    thr = T_QTR;
            3'd3:    thr = T_3QTR;
            default: thr = T_HALF;
        endcase
    end

    generate
        if (RISING) begin : g_rise
            assign hit_o = (fill_i >= thr);
        end else begin : g_fall
            assign hit_o = (fill_i <= thr);
        end
    endgenerate
endmodule

// File: rtl/uirq_dma_gate.sv
// Builds the DMA requests from the enables, fills and level hits.
// Assumes err_i is the OR of the raw receive error flags.
module uirq_dma_gate
    import uirq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int FILL_W = $clog2(DEPTH + 1)
) (
    input  dma_ctl_t          ctl_i,
    input  logic              err_i,
    input  logic [FILL_W-1:0] rx_fill_i,
    input  logic [FILL_W-1:0] tx_fill_i,
    input  logic              rx_lvl_i,
    input  logic              tx_lvl_i,
    output logic              rx_single_o,
    output logic              rx_burst_o,
    output logic              tx_single_o,
    output logic              tx_burst_o
);
    localparam logic [FILL_W-1:0] FULL = FILL_W'(DEPTH);

    logic rx_ok;

    // Receive path is open when enabled and not held by an error.
    always_comb rx_ok = ctl_i.rx_en && !(ctl_i.on_err && err_i);

    assign rx_single_o = rx_ok && (rx_fill_i != '0);
    assign rx_burst_o  = rx_ok && rx_lvl_i;
    assign tx_single_o = ctl_i.tx_en && (tx_fill_i < FULL);
    assign tx_burst_o  = ctl_i.tx_en && tx_lvl_i;
endmodule

// File: rtl/uart_irq_dma_ctrl.sv
// Top: interrupt flag collection, masking, FIFO thresholds and DMA gating.
// Assumes single-cycle event pulses and a combinational read port.
module uart_irq_dma_ctrl
    import uirq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int FILL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_W-1:0]  evt_i,
    input  logic [FILL_W-1:0] rx_fill_i,
    input  logic [FILL_W-1:0] tx_fill_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [REG_W-1:0]  wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [REG_W-1:0]  rd_data_o,
    output logic              irq_o,
    output logic              rx_lvl_o,
    output logic              tx_lvl_o,
    output logic              rx_dma_single_o,
    output logic              rx_dma_burst_o,
    output logic              tx_dma_single_o,
    output logic              tx_dma_burst_o
);
    localparam logic [2:0] LVL_RST = 3'd2;

    logic [SRC_W-1:0] raw_q, mask_q, masked;
    logic [SRC_W-1:0] clr_vec;
    logic             mask_we;
    logic [2:0]       rx_sel_q, tx_sel_q;
    dma_ctl_t         dma_q;

    // Write decode for the clear strobe and the mask load.
    always_comb begin
        mask_we = wr_en_i && (wr_addr_i == A_MASK);
        clr_vec = (wr_en_i && (wr_addr_i == A_CLR)) ? wr_data_i : '0;
    end

    // Level-select and DMA-control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_sel_q <= LVL_RST;
            tx_sel_q <= LVL_RST;
            dma_q    <= '0;
        end else if (wr_en_i) begin
            if (wr_addr_i == A_LVL) begin
                rx_sel_q <= wr_data_i[2:0];
                tx_sel_q <= wr_data_i[6:4];
            end
            if (wr_addr_i == A_DMA) dma_q <= dma_ctl_t'(wr_data_i[2:0]);
        end
    end

    uirq_flags #(.W(SRC_W), .VALID(SRC_VALID)) i_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt_i),
        .clr_i    (clr_vec),
        .mask_we_i(mask_we),
        .mask_d_i (wr_data_i),
        .raw_o    (raw_q),
        .mask_o   (mask_q),
        .masked_o (masked)
    );

    uirq_level #(.DEPTH(DEPTH), .FILL_W(FILL_W), .RISING(1'b1)) i_rx_lvl (
        .sel_i (rx_sel_q),
        .fill_i(rx_fill_i),
        .hit_o (rx_lvl_o)
    );

    uirq_level #(.DEPTH(DEPTH), .FILL_W(FILL_W), .RISING(1'b0)) i_tx_lvl (
        .sel_i (tx_sel_q),
        .fill_i(tx_fill_i),
        .hit_o (tx_lvl_o)
    );

    uirq_dma_gate #(.DEPTH(DEPTH), .FILL_W(FILL_W)) i_dma (
        .ctl_i      (dma_q),
        .err_i      (|(raw_q & ERR_BITS)),
        .rx_fill_i  (rx_fill_i),
        .tx_fill_i  (tx_fill_i),
        .rx_lvl_i   (rx_lvl_o),
        .tx_lvl_i   (tx_lvl_o),
        .rx_single_o(rx_dma_single_o),
        .rx_burst_o (rx_dma_burst_o),
        .tx_single_o(tx_dma_single_o),
        .tx_burst_o (tx_dma_burst_o)
    );

    assign irq_o = |masked;

    // Register read multiplexer.
    always_comb begin
        rd_data_o = '0;
        case (rd_addr_i)
            A_MASK:  rd_data_o = mask_q;
            A_RAW:   rd_data_o = raw_q;
            A_MSK:   rd_data_o = masked;
            A_LVL:   rd_data_o = REG_W'({tx_sel_q, 1'b0, rx_sel_q});
            A_DMA:   rd_data_o = REG_W'(dma_q);
            default: rd_data_o = '0;
        endcase
    end
endmodule

// File: rtl/uirq_checker.sv
// Assertion checker bound into uart_irq_dma_ctrl.
// Assumes it sees the top's ports plus the raw, mask and DMA state.
module uirq_checker
    import uirq_pkg::*;
#(
    parameter int FILL_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SRC_W-1:0]  evt_i,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] wr_addr_i,
    input logic [REG_W-1:0]  wr_data_i,
    input logic [SRC_W-1:0]  raw_i,
    input logic [SRC_W-1:0]  mask_i,
    input logic [2:0]        dma_i,
    input logic [FILL_W-1:0] rx_fill_i,
    input logic              irq_o,
    input logic              rx_lvl_o,
    input logic              rx_dma_single_o,
    input logic              rx_dma_burst_o
);
    logic [SRC_W-1:0] clr_now;
    logic [SRC_W-1:0] evt_v;

    // Clear request and valid events seen this cycle.
    always_comb begin
        clr_now = (wr_en_i && (wr_addr_i == A_CLR)) ? wr_data_i : '0;
        evt_v   = evt_i & SRC_VALID;
    end

    p_unused_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_i & ~SRC_VALID) == '0);

    p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_v != '0) |=> ((raw_i & $past(evt_v)) == $past(evt_v)));

    p_fall_needs_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(raw_i) & ~raw_i & ~$past(clr_now)) == '0));

    p_reset_quiet_r5: assert property (@(posedge clk)
        !rst_n |=> !irq_o);

    p_irq_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((raw_i & mask_i) != '0));

    p_rx_lvl_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_lvl_o |-> (rx_fill_i != '0));

    p_err_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_i[2] && ((raw_i & ERR_BITS) != '0)) |-> (!rx_dma_single_o && !rx_dma_burst_o));
endmodule

bind uart_irq_dma_ctrl uirq_checker #(.FILL_W(FILL_W)) i_uirq_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .evt_i          (evt_i),
    .wr_en_i        (wr_en_i),
    .wr_addr_i      (wr_addr_i),
    .wr_data_i      (wr_data_i),
    .raw_i          (raw_q),
    .mask_i         (mask_q),
    .dma_i          (dma_q),
    .rx_fill_i      (rx_fill_i),
    .irq_o          (irq_o),
    .rx_lvl_o       (rx_lvl_o),
    .rx_dma_single_o(rx_dma_single_o),
    .rx_dma_burst_o (rx_dma_burst_o)
);

// File: tb/test_uart_irq_dma_ctrl.sv
// Bench: a behavioural reference model compared with the outputs on every clock.
module test_uart_irq_dma_ctrl;
    localparam int DEPTH = 16;
    localparam int FW = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [16:0] evt = '0;
    logic [FW-1:0] rxf = '0, txf = '0;
    logic we = 1'b0;
    logic [2:0] wa = '0, ra = '0;
    logic [16:0] wd = '0;
    logic [16:0] rd;
    logic irq, rxl, txl, rxs, rxb, txs, txb;

    always #10 clk = ~clk;

    uart_irq_dma_ctrl #(.DEPTH(DEPTH)) i_uart_irq_dma_ctrl (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .rx_fill_i(rxf), .tx_fill_i(txf),
        .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd), .rd_addr_i(ra), .rd_data_o(rd),
        .irq_o(irq), .rx_lvl_o(rxl), .tx_lvl_o(txl),
        .rx_dma_single_o(rxs), .rx_dma_burst_o(rxb),
        .tx_dma_single_o(txs), .tx_dma_burst_o(txb)
    );

    int checks = 0;
    int failures = 0;
    logic [16:0] m_raw, m_mask;
    logic [6:0] m_lvl;
    logic [2:0] m_dma;

    function automatic int thr(input int code);
        if (code == 1) return DEPTH / 4;
        if (code == 3) return (DEPTH * 3) / 4;
        return DEPTH / 2;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Advance one clock: update the model at the edge, then compare.
    task automatic cyc();
        logic [16:0] clr, mmsk, exp_rd;
        bit e_rxl, e_txl, gate;
        @(posedge clk);
        if (!rst_n) begin
            m_raw = '0; m_mask = '0; m_lvl = 7'h22; m_dma = '0;
        end else begin
            clr = (we && wa == 3'd3) ? wd : 17'h0;
            m_raw = (m_raw & ~clr) | (evt & 17'h1FFF2);
            if (we && wa == 3'd0) m_mask = wd;
            if (we && wa == 3'd4) m_lvl = wd[6:0] & 7'h77;
            if (we && wa == 3'd5) m_dma = wd[2:0];
        end
        #2;
        mmsk = m_raw & m_mask;
        e_rxl = int'(rxf) >= thr(int'(m_lvl[2:0]));
        e_txl = int'(txf) <= thr(int'(m_lvl[6:4]));
        gate = m_dma[2] && ((m_raw & 17'h00780) != 0);
        chk("R6", "irq", irq, (mmsk != 0));
        chk("R7", "rx_lvl", rxl, e_rxl);
        chk("R8", "tx_lvl", txl, e_txl);
        chk("R10", "rx_single", rxs, m_dma[0] && !gate && rxf != 0);
        chk("R10", "rx_burst", rxb, m_dma[0] && !gate && e_rxl);
        chk("R9", "tx_single", txs, m_dma[1] && int'(txf) < DEPTH);
        chk("R9", "tx_burst", txb, m_dma[1] && e_txl);
        case (ra)
            3'd0: exp_rd = m_mask;
            3'd1: exp_rd = m_raw;
            3'd2: exp_rd = mmsk;
            3'd4: exp_rd = 17'(m_lvl);
            3'd5: exp_rd = 17'(m_dma);
            default: exp_rd = '0;
        endcase
        chk("R11", "rd_data", rd, exp_rd);
    endtask

    task automatic wr(input logic [2:0] a, input logic [16:0] d);
        we = 1'b1; wa = a; wd = d;
        cyc();
        we = 1'b0; wd = '0;
    endtask

    task automatic pulse(input logic [16:0] e);
        evt = e;
        cyc();
        evt = '0;
    endtask

    initial begin
        #(20 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // Reset state (R5, R7, R9)
        repeat (3) cyc();
        rst_n = 1'b1;
        ra = 3'd4; cyc();
        chk("R7", "level reset", rd, 17'h22);
        ra = 3'd0; cyc();
        chk("R5", "mask reset", rd, 0);
        chk("R5", "irq after reset", irq, 0);

        // Every position pulsed once; unused positions ignored (R1, R2)
        ra = 3'd1;
        for (int b = 0; b < 17; b++) begin
            pulse(17'(1) << b);
            cyc();
        end
        chk("R1", "raw after sweep", rd, 17'h1FFF2);
        chk("R5", "irq with mask 0", irq, 0);
        ra = 3'd3; cyc();
        chk("R3", "clear reads 0", rd, 0);

        // Open all masks, then clear one flag at a time (R3, R4, R6)
        wr(3'd0, 17'h1FFFF);
        ra = 3'd2;
        for (int b = 0; b < 17; b++) wr(3'd3, 17'(1) << b);
        chk("R3", "all cleared", rd, 0);
        chk("R6", "irq after clears", irq, 0);

        // Set and clear of the same flag in one cycle (R3)
        evt = 17'h00010; we = 1'b1; wa = 3'd3; wd = 17'h00010;
        cyc();
        evt = '0; we = 1'b0; wd = '0;
        ra = 3'd1; cyc();
        chk("R3", "set wins", rd, 17'h00010);
        wr(3'd3, 17'h1FFFF);

        // Selective mask (R4, R5)
        pulse(17'h1FFF2);
        wr(3'd0, 17'h00080);
        ra = 3'd2; cyc();
        chk("R4", "masked single", rd, 17'h00080);
        wr(3'd0, 17'h0);
        chk("R5", "mask blocks", irq, 0);
        ra = 3'd1; cyc();
        chk("R2", "raw kept", rd, 17'h1FFF2);
        wr(3'd3, 17'h1FFFF);

        // Threshold sweep for every code (R7, R8)
        ra = 3'd4;
        for (int c = 0; c < 8; c++) begin
            wr(3'd4, 17'(c | (c << 4) | 8));
            for (int f = 0; f <= DEPTH; f++) begin
                rxf = FW'(f); txf = FW'(DEPTH - f);
                cyc();
            end
        end
        wr(3'd4, 17'h0031);
        rxf = FW'(DEPTH / 4); txf = FW'(DEPTH * 3 / 4); cyc();
        chk("R7", "rx at quarter", rxl, 1);
        chk("R8", "tx at three quarters", txl, 1);
        rxf = FW'(DEPTH / 4 - 1); txf = FW'(DEPTH * 3 / 4 + 1); cyc();
        chk("R7", "rx below quarter", rxl, 0);
        chk("R8", "tx above three quarters", txl, 0);

        // DMA enables and error gate (R9, R10)
        ra = 3'd5;
        rxf = FW'(DEPTH); txf = '0;
        wr(3'd5, 17'h3);
        chk("R9", "rx burst on", rxb, 1);
        chk("R9", "tx single on", txs, 1);
        txf = FW'(DEPTH); cyc();
        chk("R9", "tx single full", txs, 0);
        wr(3'd5, 17'h7);
        for (int b = 7; b <= 10; b++) begin
            pulse(17'(1) << b);
            chk("R10", "rx gated", rxs, 0);
            wr(3'd3, 17'(1) << b);
            chk("R10", "rx released", rxs, 1);
        end
        pulse(17'h00010);
        chk("R10", "non-error no gate", rxb, 1);
        pulse(17'h00100);
        wr(3'd5, 17'h3);
        chk("R10", "gate off", rxb, 1);
        wr(3'd5, 17'h0);
        chk("R9", "rx disabled", rxs, 0);

        // Reset in mid-run (R11)
        wr(3'd0, 17'h1FFFF);
        wr(3'd5, 17'h7);
        rst_n = 1'b0; cyc(); rst_n = 1'b1;
        ra = 3'd1; cyc();
        chk("R11", "raw after reset", rd, 0);
        ra = 3'd7; cyc();
        chk("R11", "unmapped read", rd, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule